// File: doc/BRIEF.md
# Host-to-Peripheral Internal Bus Bridge

This block links a 32-bit host bus to a set of on-chip peripheral modules. The host presents a request with an address, a direction, four byte enables and write data. The bridge decodes a three-bit window field of the address into one active-low select per peripheral. It then drives registered copies of the address, the write data, the direction and the active-low read or per-byte write strobes onto a bus that every peripheral sees. When a read completes, the bridge captures the selected peripheral's read data and returns it to the host with a one-cycle done pulse.

The addressed peripheral can stretch a cycle by holding its own active-low wait line low. If that line stays low for too long, the bridge ends the cycle and flags a timeout. A reserved address window holds a small control register. Its bits drive an active-low reset line and an active-high standby line for each peripheral. After system reset, every peripheral is held in reset.

Top module: `pbus_bridge`

## Requirements
- R1: Host address bits [23:21] form the window. A window value m below N_MOD drives pm_sel_n[m] low and leaves every other select high, whatever the other address bits are. This covers both register and buffer offsets and either value of bit 25.
- R2: During a cycle, pm_addr carries host address bits [20:1], and pm_a24 and pm_a25 carry bits 24 and 25. All of them are held for the whole cycle.
- R3: For a write to a module, pm_we_n[i] is low exactly when hst_be[i] is set. Lane i carries hst_wdata[8i+7:8i] on pm_wdata, pm_rd_n stays high and pm_dir is 0. For a read, pm_rd_n is low, all pm_we_n are high and pm_dir is 1.
- R4: On a read of a module, hst_rdata equals that module's slice of pm_rdata (module m at bits [32m+31:32m]) as sampled on the completing clock edge. On a write, hst_rdata is zero.
- R5: If the selected module holds pm_wait_n low for W sampled clocks (W below TMO), hst_done is high in the cycle that starts W+2 clocks after the request is taken. The wait lines of modules that are not selected have no effect.
- R6: A window value from N_MOD up to 6 asserts no select and no strobe. A read there returns zero, and hst_done follows after one clock with no wait.
- R7: Window 7 is the control register. Bits [N_MOD-1:0] are written through byte lane 0 and drive pm_rst_n as their inverse. Bits [16+N_MOD-1:16] are written through byte lane 2 and drive pm_stby directly. Other lanes do not change the register, and a read returns both fields at the same positions.
- R8: While reset is asserted and right after it, pm_rst_n is all zeros, pm_stby is all zeros, every select and strobe is high, and hst_done is low.
- R9: If the selected wait line stays low for TMO sampled clocks, the cycle ends TMO+1 clocks after it was taken, with hst_tmo high and hst_rdata zero. In every other cycle, hst_tmo is low when hst_done is high.
- R10: Selects and strobes are asserted in the cycle after the request is taken. They stay asserted while the cycle is stretched and all release on the completing edge, where hst_done pulses for a single cycle. The next cycle starts no sooner than one idle clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host request, held with its fields until hst_done |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | HAW-1 | Host byte address bits [HAW-1:1] |
| hst_be | input | DW/8 | Byte enables |
| hst_wdata | input | DW | Host write data |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_tmo | output | 1 | Cycle ended by wait timeout (valid with hst_done) |
| hst_rdata | output | DW | Read data (valid with hst_done) |
| pm_sel_n | output | N_MOD | Active-low module selects |
| pm_wait_n | input | N_MOD | Active-low wait from each module |
| pm_rdata | input | N_MOD*DW | Read data of all modules, module m at [m*DW +: DW] |
| pm_rst_n | output | N_MOD | Active-low module resets |
| pm_stby | output | N_MOD | Active-high module standby |
| pm_addr | output | 20 | Broadcast address bits [20:1] |
| pm_a24 | output | 1 | Broadcast address bit 24 |
| pm_a25 | output | 1 | Broadcast address bit 25 |
| pm_wdata | output | DW | Broadcast write data |
| pm_dir | output | 1 | Direction: 1 = read, 0 = write |
| pm_rd_n | output | 1 | Active-low read strobe |
| pm_we_n | output | DW/8 | Active-low per-byte write strobes |

## Verification
The bench puts each request on a falling edge, and the bridge takes it on the next rising edge. Selects, strobes, address and data are due one edge later, so they are checked at the first falling edge after that. hst_done is due at the falling edge W+2 after the request is taken, or at TMO+1 for a timeout. The bench counts falling edges up to that point and checks that none of the stretched cycles shows a released select. Read data and the timeout flag are checked together with done. The idle gap, the released selects and the control outputs are checked one falling edge later.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [1:0] {
      BR_IDLE = 2'd0,
      BR_ACC  = 2'd1,
      BR_DONE = 2'd2
   } br_state_e;

   localparam int WIN_LSB = 21;
   localparam int WIN_W   = 3;
endpackage

// File: rtl/pbus_addr_decode.sv
module pbus_addr_decode #(
   parameter int N_MOD = 4,
   parameter int WIN_W = 3
) (
   input  logic [WIN_W-1:0] win,
   output logic             mod_hit,
   output logic             ctl_hit
);
   localparam int CTL_WIN = (1 << WIN_W) - 1;

   if (N_MOD >= CTL_WIN) begin : g_bad_n
      $error("N_MOD must leave the top window for the control register");
   end

   always_comb begin
      mod_hit = (int'(win) < N_MOD);
      ctl_hit = (int'(win) == CTL_WIN);
      assert_hit_excl_R1: assert (!(mod_hit && ctl_hit));
   end
endmodule

// File: rtl/pbus_wait_timer.sv
module pbus_wait_timer #(
   parameter int TMO = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = $clog2(TMO + 1);
   localparam logic [CW-1:0] LAST = CW'(TMO - 1);

   if (TMO < 2) begin : g_bad_tmo
      $error("TMO must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign expire = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!expire) cnt_q <= cnt_q + 1'b1;
      else             cnt_q <= '0;
   end

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);
endmodule

// File: rtl/pbus_ctrl_reg.sv
module pbus_ctrl_reg #(
   parameter int N_MOD = 4,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             lane_rst,
   input  logic             lane_stby,
   input  logic [N_MOD-1:0] rst_din,
   input  logic [N_MOD-1:0] stby_din,
   output logic [N_MOD-1:0] rst_bits,
   output logic [N_MOD-1:0] stby_bits,
   output logic [DW-1:0]    rd_val
);
   localparam int STBY_LSB = 16;

   if (N_MOD > 8) begin : g_bad_lane
      $error("each control field must fit one byte lane");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_bits  <= '1;
         stby_bits <= '0;
      end else if (we) begin
         if (lane_rst)  rst_bits  <= rst_din;
         if (lane_stby) stby_bits <= stby_din;
      end
   end

   always_comb begin
      rd_val = '0;
      rd_val[N_MOD-1:0] = rst_bits;
      rd_val[STBY_LSB +: N_MOD] = stby_bits;
   end

   assert_rst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rst_bits) && $stable(stby_bits));
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
   import pbus_pkg::*;
#(
   parameter int N_MOD = 4,
   parameter int DW    = 32,
   parameter int HAW   = 26,
   parameter int TMO   = 255
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hst_req,
   input  logic                  hst_wr,
   input  logic [HAW-1:1]        hst_addr,
   input  logic [DW/8-1:0]       hst_be,
   input  logic [DW-1:0]         hst_wdata,
   output logic                  hst_done,
   output logic                  hst_tmo,
   output logic [DW-1:0]         hst_rdata,
   output logic [N_MOD-1:0]      pm_sel_n,
   input  logic [N_MOD-1:0]      pm_wait_n,
   input  logic [N_MOD*DW-1:0]   pm_rdata,
   output logic [N_MOD-1:0]      pm_rst_n,
   output logic [N_MOD-1:0]      pm_stby,
   output logic [19:0]           pm_addr,
   output logic                  pm_a24,
   output logic                  pm_a25,
   output logic [DW-1:0]         pm_wdata,
   output logic                  pm_dir,
   output logic                  pm_rd_n,
   output logic [DW/8-1:0]       pm_we_n
);
   localparam int BE_W = DW / 8;

   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end
   if (HAW != 26) begin : g_bad_haw
      $error("HAW must be 26");
   end
   if (N_MOD < 1) begin : g_bad_n
      $error("N_MOD must be at least 1");
   end

   br_state_e        st_q;
   logic [WIN_W-1:0] win, win_q;
   logic             mod_hit, ctl_hit, hit_q, ctl_q;
   logic             wait_ok, expire, run, ctl_we;
   logic [DW-1:0]    sel_rd, ctl_val;
   logic [DW-1:0]    mod_rd [N_MOD];
   logic [N_MOD-1:0] rst_bits, stby_bits, sel_n_d;
   logic             take;

   assign win  = hst_addr[WIN_LSB +: WIN_W];
   assign take = (st_q == BR_IDLE) && hst_req;

   pbus_addr_decode #(.N_MOD(N_MOD), .WIN_W(WIN_W)) u_dec (
      .win(win), .mod_hit(mod_hit), .ctl_hit(ctl_hit));

   assign ctl_we = take && ctl_hit && hst_wr;

   pbus_ctrl_reg #(.N_MOD(N_MOD), .DW(DW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we),
      .lane_rst(hst_be[0]), .lane_stby(hst_be[2]),
      .rst_din(hst_wdata[N_MOD-1:0]), .stby_din(hst_wdata[16 +: N_MOD]),
      .rst_bits(rst_bits), .stby_bits(stby_bits), .rd_val(ctl_val));

   assign pm_rst_n = ~rst_bits;
   assign pm_stby  = stby_bits;

   for (genvar g = 0; g < N_MOD; g++) begin : g_rd
      assign mod_rd[g] = pm_rdata[g*DW +: DW];
   end

   always_comb begin
      sel_rd  = '0;
      wait_ok = 1'b1;
      for (int i = 0; i < N_MOD; i++) begin
         if (hit_q && (int'(win_q) == i)) begin
            sel_rd  = mod_rd[i];
            wait_ok = pm_wait_n[i];
         end
      end
      for (int i = 0; i < N_MOD; i++) begin
         sel_n_d[i] = !(mod_hit && (int'(win) == i));
      end
   end

   assign run = (st_q == BR_ACC) && !wait_ok;

   pbus_wait_timer #(.TMO(TMO)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= BR_IDLE;
         win_q     <= '0;
         hit_q     <= 1'b0;
         ctl_q     <= 1'b0;
         pm_sel_n  <= '1;
         pm_rd_n   <= 1'b1;
         pm_we_n   <= '1;
         pm_dir    <= 1'b1;
         pm_addr   <= '0;
         pm_a24    <= 1'b0;
         pm_a25    <= 1'b0;
         pm_wdata  <= '0;
         hst_done  <= 1'b0;
         hst_tmo   <= 1'b0;
         hst_rdata <= '0;
      end else begin
         case (st_q)
            BR_IDLE: begin
               hst_done <= 1'b0;
               if (hst_req) begin
                  st_q     <= BR_ACC;
                  win_q    <= win;
                  hit_q    <= mod_hit;
                  ctl_q    <= ctl_hit;
                  pm_sel_n <= sel_n_d;
                  pm_rd_n  <= !(mod_hit && !hst_wr);
                  pm_we_n  <= (mod_hit && hst_wr) ? ~hst_be : '1;
                  pm_dir   <= !hst_wr;
                  pm_addr  <= hst_addr[20:1];
                  pm_a24   <= hst_addr[24];
                  pm_a25   <= hst_addr[25];
                  pm_wdata <= hst_wdata;
               end
            end
            BR_ACC: begin
               if (wait_ok || expire) begin
                  st_q     <= BR_DONE;
                  pm_sel_n <= '1;
                  pm_rd_n  <= 1'b1;
                  pm_we_n  <= '1;
                  hst_done <= 1'b1;
                  hst_tmo  <= !wait_ok;
                  if (!wait_ok || !pm_dir) hst_rdata <= '0;
                  else if (hit_q)          hst_rdata <= sel_rd;
                  else if (ctl_q)          hst_rdata <= ctl_val;
                  else                     hst_rdata <= '0;
               end
            end
            default: begin
               st_q     <= BR_IDLE;
               hst_done <= 1'b0;
            end
         endcase
      end
   end

   assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~pm_sel_n));
   assert_strobe_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pm_rd_n || !(&pm_we_n)) |-> !(&pm_sel_n));
   assert_rd_we_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!pm_rd_n && !(&pm_we_n)));
   assert_rd_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pm_rd_n |-> pm_dir);
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&pm_sel_n) && $past(!(&pm_sel_n))) |-> $stable(pm_addr) && $stable(pm_wdata));
   assert_idle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&pm_sel_n) |=> &pm_sel_n);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hst_done |=> !hst_done);
   assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hst_done |-> (&pm_sel_n) && pm_rd_n && (&pm_we_n));
   assert_tmo_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_done && hst_tmo) |-> hst_rdata == '0);
endmodule

// File: tb/pbus_bridge_tb.sv
module pbus_bridge_tb_top;
   localparam int N   = 4;
   localparam int TMO = 255;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hst_req = 1'b0, hst_wr = 1'b0;
   logic [25:1]   hst_addr = '0;
   logic [3:0]    hst_be = '0;
   logic [31:0]   hst_wdata = '0;
   logic          hst_done, hst_tmo;
   logic [31:0]   hst_rdata;
   logic [N-1:0]  pm_sel_n, pm_rst_n, pm_stby;
   logic [N-1:0]  pm_wait_n = '1;
   logic [N*32-1:0] pm_rdata = '0;
   logic [19:0]   pm_addr;
   logic          pm_a24, pm_a25, pm_dir, pm_rd_n;
   logic [31:0]   pm_wdata;
   logic [3:0]    pm_we_n;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [N-1:0] rst_m = '1, stby_m = '0;

   always #10 clk = ~clk;

   pbus_bridge #(.N_MOD(N), .DW(32), .HAW(26), .TMO(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_be(hst_be), .hst_wdata(hst_wdata),
      .hst_done(hst_done), .hst_tmo(hst_tmo), .hst_rdata(hst_rdata),
      .pm_sel_n(pm_sel_n), .pm_wait_n(pm_wait_n), .pm_rdata(pm_rdata),
      .pm_rst_n(pm_rst_n), .pm_stby(pm_stby), .pm_addr(pm_addr),
      .pm_a24(pm_a24), .pm_a25(pm_a25), .pm_wdata(pm_wdata),
      .pm_dir(pm_dir), .pm_rd_n(pm_rd_n), .pm_we_n(pm_we_n));

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [N-1:0] exp_sel(input logic [2:0] w);
      return (int'(w) < N) ? ~(N'(1) << w) : '1;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [2:0] w, input bit wr,
                                          input logic [N*32-1:0] rd);
      if (wr) return '0;
      if (int'(w) < N) return rd[w*32 +: 32];
      if (w == 3'd7) return (32'(stby_m) << 16) | 32'(rst_m);
      return '0;
   endfunction

   // one host cycle; wl = wait clocks, forever_wait = never release
   task automatic txn(input logic [25:1] a, input bit wr, input logic [3:0] be,
                      input logic [31:0] wd, input int wl, input bit forever_wait);
      logic [2:0] w;
      bit hit;
      int j, exp_j;
      logic [31:0] exp_r;
      w   = a[23:21];
      hit = int'(w) < N;
      @(negedge clk);
      pm_rdata  = {$urandom, $urandom, $urandom, $urandom};
      pm_wait_n = N'($urandom);
      if (hit) pm_wait_n[w] = (wl == 0 && !forever_wait);
      hst_req = 1'b1; hst_wr = wr; hst_addr = a; hst_be = be; hst_wdata = wd;
      exp_r = forever_wait ? 32'h0 : exp_rd(w, wr, pm_rdata);
      exp_j = forever_wait ? TMO + 1 : (hit ? wl + 2 : 2);
      j = 0;
      while (1) begin
         @(negedge clk);
         j++;
         if (j == 1) begin
            hst_req = 1'b0;
            chk(pm_sel_n == exp_sel(w), "R1 select", 32'(pm_sel_n), 32'(exp_sel(w)));
            if (hit) begin
               chk(pm_addr == a[20:1] && pm_a24 == a[24] && pm_a25 == a[25], "R2 address",
                   {pm_a25, pm_a24, 10'd0, pm_addr}, {a[25], a[24], 10'd0, a[20:1]});
               chk(pm_we_n == (wr ? ~be : 4'hF), "R3 write strobes", 32'(pm_we_n),
                   32'(wr ? ~be : 4'hF));
               chk(pm_rd_n == wr && pm_dir == !wr, "R3 read strobe/dir",
                   {30'd0, pm_rd_n, pm_dir}, {30'd0, wr, !wr});
               if (wr) chk(pm_wdata == wd, "R3 write data", pm_wdata, wd);
            end else begin
               chk(pm_rd_n && pm_we_n == 4'hF, "R6 no strobe", {27'd0, pm_rd_n, pm_we_n},
                   32'h1F);
            end
         end
         if (hst_done) break;
         if (j > 1) chk(pm_sel_n == exp_sel(w), "R10 select held", 32'(pm_sel_n),
                        32'(exp_sel(w)));
         if (hit && !forever_wait && j == wl + 1) pm_wait_n[w] = 1'b1;
         if (j > TMO + 8) break;
      end
      chk(j == exp_j, "R5 done latency", 32'(j), 32'(exp_j));
      chk(hst_tmo == forever_wait, "R9 timeout flag", 32'(hst_tmo), 32'(forever_wait));
      chk(hst_rdata == exp_r, "R4 read data", hst_rdata, exp_r);
      chk(pm_sel_n == '1 && pm_rd_n && pm_we_n == 4'hF, "R10 release at done",
          {pm_sel_n, pm_rd_n, pm_we_n}, {{N{1'b1}}, 5'h1F});
      if (w == 3'd7 && wr) begin
         if (be[0]) rst_m  = wd[N-1:0];
         if (be[2]) stby_m = wd[16 +: N];
      end
      @(negedge clk);
      chk(!hst_done, "R10 done pulse", 32'(hst_done), 32'h0);
      chk(pm_sel_n == '1, "R10 idle gap", 32'(pm_sel_n), 32'hF);
      chk(pm_rst_n == ~rst_m && pm_stby == stby_m, "R7 ctrl outputs",
          {pm_rst_n, pm_stby}, {~rst_m, stby_m});
      pm_wait_n = '1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [25:1] a;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk(pm_rst_n == '0 && pm_stby == '0, "R8 reset ctrl", {pm_rst_n, pm_stby}, 32'h0);
      chk(pm_sel_n == '1 && pm_rd_n && pm_we_n == 4'hF && !hst_done, "R8 reset bus",
          {pm_sel_n, pm_rd_n, pm_we_n, hst_done}, {{N{1'b1}}, 6'h3E});
      rst_n = 1'b1;
      @(negedge clk);
      chk(pm_rst_n == '0, "R8 reset after release", 32'(pm_rst_n), 32'h0);

      // R7 directed: lanes of the control register
      a = '0; a[23:21] = 3'd7;
      txn(a, 1'b1, 4'b0001, 32'h0000_000A, 0, 0);
      txn(a, 1'b1, 4'b0100, 32'h0005_0000, 0, 0);
      txn(a, 1'b1, 4'b1010, 32'hFFFF_FFFF, 0, 0);
      txn(a, 1'b0, 4'b1111, 32'h0, 0, 0);
      txn(a, 1'b1, 4'b0101, 32'h0000_0000, 0, 0);
      // R6 directed: unmapped windows
      a = 25'h0ABCDE; a[23:21] = 3'd5;
      txn(a, 1'b0, 4'hF, 32'h0, 0, 0);
      a[23:21] = 3'd4;
      txn(a, 1'b1, 4'hF, 32'h1234_5678, 0, 0);
      // R1 directed: register and buffer ranges, bit 25 both ways
      a = '0; a[23:21] = 3'd3; a[25] = 1'b1;
      txn(a, 1'b0, 4'hF, 32'h0, 0, 0);
      a = 25'h1FFFFF; a[23:21] = 3'd0; a[25] = 1'b0; a[24] = 1'b1;
      txn(a, 1'b1, 4'b1001, 32'hA5A5_5A5A, 0, 0);
      // R5 long wait, R9 timeout, then a normal cycle
      a = 25'h00F0F0; a[23:21] = 3'd1;
      txn(a, 1'b0, 4'hF, 32'h0, 20, 0);
      a[23:21] = 3'd2;
      txn(a, 1'b0, 4'hF, 32'h0, 0, 1);
      txn(a, 1'b0, 4'hF, 32'h0, 3, 0);
      // random mix
      for (int i = 0; i < 150; i++) begin
         a = 25'($urandom);
         a[23:21] = 3'($urandom_range(0, 7));
         txn(a, 1'($urandom), 4'($urandom), $urandom,
             ($urandom_range(0, 9) == 0) ? int'($urandom_range(10, 40))
                                         : int'($urandom_range(0, 5)), 0);
      end
      finish_run();
   end
endmodule